// File: doc/BRIEF.md
# Audio Sample-Rate Tick Generator

The block turns a fixed reference tick, nominally 1.4112 MHz presented as a one-cycle enable pulse in the system clock domain, into three sample-rate strobes. One strobe serves the first playback channel, one the second playback channel and one the record channel. Each strobe is high for exactly one system clock per sample period. Downstream sample movers use these strobes to pace their transfers.

The first playback channel picks one of four fixed rates with a two-bit code. The rates are obtained by dividing the reference by 256, 128, 64 or 32, which gives about 5512, 11025, 22050 and 44100 samples per second. The second playback channel and the record channel both run at the reference divided by a 13-bit programmable field plus two. Each of the three channels has its own enable. A lock mode makes the second playback channel follow the first channel's strobe instead of its own divider.

Top module: `audio_rate_ticker`

## Requirements
- R1: While reset is held and afterwards until an enable is raised, all three strobes stay low.
- R2: With `p1_en` high, `p1_tick` fires once every 256, 128, 64 or 32 reference ticks for `p1_rate_sel` codes 0, 1, 2 and 3 respectively.
- R3: With `p2_en` high and `sync_en` low, `p2_tick` fires once every `share_div + 2` reference ticks; field value 0 gives 2 and field value 8191 gives 8193.
- R4: With `rec_en` high, `rec_tick` fires once every `share_div + 2` reference ticks, independently of whether `p2_en` is set.
- R5: While `sync_en` and `p2_en` are high, `p2_tick` is high in exactly the cycles where `p1_tick` is high, and it never ticks on its own divider.
- R6: Every strobe is high for a single clock and is low in the following clock.
- R7: A new `share_div` or `p1_rate_sel` value is captured only at the first reference tick of a period; a change made after that tick does not alter the period in progress.
- R8: While a channel's enable is low, its strobe stays low and its count is cleared; after the enable rises, the first strobe follows after exactly one full period of reference ticks.
- R9: A strobe rises only two clocks after a reference tick; with no reference ticks, no strobe fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse at the reference rate |
| p1_en | input | 1 | Enable for the first playback channel |
| p1_rate_sel | input | 2 | Fixed-rate code for the first playback channel |
| p2_en | input | 1 | Enable for the second playback channel |
| rec_en | input | 1 | Enable for the record channel |
| share_div | input | 13 | Divider field shared by second playback and record |
| sync_en | input | 1 | Locks second playback to the first channel's strobe |
| p1_tick | output | 1 | Sample strobe, first playback channel |
| p2_tick | output | 1 | Sample strobe, second playback channel |
| rec_tick | output | 1 | Sample strobe, record channel |

## Verification
The bench goes after the smallest divider field, where a design that divided by the field alone would strobe on every reference tick or never, and the largest field, where a counter one bit too narrow would wrap and give a short period. It changes the divider part-way through a period: a design that reloads immediately shortens or stretches that period instead of finishing it. It toggles enables mid-period and stops the reference entirely, catching a counter that keeps its count across a disable or a strobe that runs without reference ticks. Under lock mode it checks cycle alignment with the first channel, which exposes a mux that picks the wrong source or adds a cycle of skew.

// File: rtl/audio_tick_pkg.sv
package audio_tick_pkg;

    // Widths of the rate fields
    parameter int DIV_W        = 13;
    parameter int SEL_W        = 2;
    // Largest first-channel divisor is 2**P1_MAX_SHIFT
    parameter int P1_MAX_SHIFT = 8;

    localparam int P1_PER_W  = P1_MAX_SHIFT + 1;
    localparam int DIV_PER_W = DIV_W + 1;

    // Registered strobes presented at the top boundary
    typedef struct packed {
        logic p1;
        logic p2;
        logic rec;
    } strobe_t;

endpackage

// File: rtl/rate_divider.sv
// Counts reference ticks and emits a one-cycle strobe every PERIOD of them.
// The period is captured at the first reference tick of each period.
module rate_divider #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic             tick;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [CNT_W-1:0] per_eff;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        per_eff   = (st_q.cnt == '0) ? period : st_q.per;
        cnt_inc   = st_q.cnt + CNT_W'(1);
        if (!en) begin
            st_d.cnt = '0;
        end else if (ref_tick) begin
            st_d.per = per_eff;
            if (cnt_inc == per_eff) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/fixed_rate_decode.sv
// Maps the first channel's rate code to a divisor: 2**(P1_MAX_SHIFT - code).
module fixed_rate_decode #(
    parameter int SEL_W        = 2,
    parameter int P1_MAX_SHIFT = 8
) (
    input  logic [SEL_W-1:0]      sel,
    output logic [P1_MAX_SHIFT:0] period
);

    localparam int NUM_CODES = 1 << SEL_W;

    logic [NUM_CODES-1:0][P1_MAX_SHIFT:0] table_w;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CODES; gi++) begin : g_code
            assign table_w[gi] = (P1_MAX_SHIFT + 1)'(1) << (P1_MAX_SHIFT - gi);
        end
    endgenerate

    assign period = table_w[sel];

endmodule

// File: rtl/audio_rate_ticker.sv
module audio_rate_ticker
    import audio_tick_pkg::*;
#(
    parameter int DIV_BITS   = audio_tick_pkg::DIV_W,
    parameter int SEL_BITS   = audio_tick_pkg::SEL_W,
    parameter int P1_SHIFT   = audio_tick_pkg::P1_MAX_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_tick,
    input  logic                p1_en,
    input  logic [SEL_BITS-1:0] p1_rate_sel,
    input  logic                p2_en,
    input  logic                rec_en,
    input  logic [DIV_BITS-1:0] share_div,
    input  logic                sync_en,
    output logic                p1_tick,
    output logic                p2_tick,
    output logic                rec_tick
);

    localparam int P1_W       = P1_SHIFT + 1;
    localparam int SH_W       = DIV_BITS + 1;
    localparam int NUM_SHARED = 2;   // index 0: second playback, 1: record

    logic [P1_W-1:0]       p1_period;
    logic                  p1_raw;
    logic [SH_W-1:0]       shared_period;
    logic [NUM_SHARED-1:0] shared_en;
    logic [NUM_SHARED-1:0] shared_raw;

    strobe_t out_d, out_q;

    fixed_rate_decode #(
        .SEL_W        (SEL_BITS),
        .P1_MAX_SHIFT (P1_SHIFT)
    ) u_decode (
        .sel    (p1_rate_sel),
        .period (p1_period)
    );

    rate_divider #(
        .CNT_W (P1_W)
    ) u_p1_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .en       (p1_en),
        .period   (p1_period),
        .tick     (p1_raw)
    );

    // Divisor is the field plus two
    assign shared_period = {1'b0, share_div} + SH_W'(2);
    // Second playback divider is held clear while locked to the first channel
    assign shared_en[0]  = p2_en & ~sync_en;
    assign shared_en[1]  = rec_en;

    genvar gc;
    generate
        for (gc = 0; gc < NUM_SHARED; gc++) begin : g_shared
            rate_divider #(
                .CNT_W (SH_W)
            ) u_div (
                .clk      (clk),
                .rst_n    (rst_n),
                .ref_tick (ref_tick),
                .en       (shared_en[gc]),
                .period   (shared_period),
                .tick     (shared_raw[gc])
            );
        end
    endgenerate

    always_comb begin
        out_d.p1  = p1_raw;
        out_d.p2  = sync_en ? (p2_en & p1_raw) : shared_raw[0];
        out_d.rec = shared_raw[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign p1_tick  = out_q.p1;
    assign p2_tick  = out_q.p2;
    assign rec_tick = out_q.rec;

endmodule

// File: rtl/audio_rate_ticker_chk.sv
module audio_rate_ticker_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_tick,
    input logic p1_en,
    input logic p2_en,
    input logic rec_en,
    input logic sync_en,
    input logic p1_tick,
    input logic p2_tick,
    input logic rec_tick
);

    AST_P1_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        p1_tick |=> !p1_tick); // R6
    AST_P2_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        p2_tick |=> !p2_tick); // R6
    AST_REC_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_tick |=> !rec_tick); // R6
    AST_P1_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        p1_tick |-> $past(ref_tick, 2)); // R9
    AST_REC_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        rec_tick |-> $past(ref_tick, 2)); // R9
    AST_SYNC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_en) && $past(p2_en)) |-> (p2_tick == p1_tick)); // R5
    AST_P1_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(p1_en) |-> !p1_tick); // R8
    AST_P2_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(p2_en) |-> !p2_tick); // R8
    AST_REC_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rec_en) |-> !rec_tick); // R8

endmodule

bind audio_rate_ticker audio_rate_ticker_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .p1_en    (p1_en),
    .p2_en    (p2_en),
    .rec_en   (rec_en),
    .sync_en  (sync_en),
    .p1_tick  (p1_tick),
    .p2_tick  (p2_tick),
    .rec_tick (rec_tick)
);

// File: tb/audio_rate_ticker_tb.sv
`timescale 1ns/1ps
module audio_rate_ticker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        p1_en = 1'b0;
    logic [1:0]  p1_rate_sel = 2'd0;
    logic        p2_en = 1'b0;
    logic        rec_en = 1'b0;
    logic [12:0] share_div = 13'd0;
    logic        sync_en = 1'b0;
    logic        p1_tick, p2_tick, rec_tick;

    int errors = 0;
    int checks = 0;
    int ref_gap = 3;       // 0 stops the reference
    int ref_total = 0;
    bit done = 0;

    always #10 clk = ~clk;

    audio_rate_ticker u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_tick    (ref_tick),
        .p1_en       (p1_en),
        .p1_rate_sel (p1_rate_sel),
        .p2_en       (p2_en),
        .rec_en      (rec_en),
        .share_div   (share_div),
        .sync_en     (sync_en),
        .p1_tick     (p1_tick),
        .p2_tick     (p2_tick),
        .rec_tick    (rec_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference tick generator
    initial begin
        int phase = 0;
        forever begin
            @(negedge clk);
            if (ref_gap == 0) begin
                ref_tick = 1'b0;
                phase = 0;
            end else if (phase >= ref_gap - 1) begin
                ref_tick = 1'b1;
                phase = 0;
            end else begin
                ref_tick = 1'b0;
                phase++;
            end
        end
    end

    always @(posedge clk) if (ref_tick) ref_total++;

    // Behavioural reference model: counts of reference ticks per channel
    int m_cnt[3], m_per[3];
    bit m_raw[3];
    bit m_o1, m_o2, m_o3;

    always @(posedge clk) begin
        bit en_v[3];
        int want[3];
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_per[i] = 0; m_raw[i] = 0; end
            m_o1 = 0; m_o2 = 0; m_o3 = 0;
        end else begin
            m_o1 = m_raw[0];
            m_o2 = sync_en ? (p2_en && m_raw[0]) : m_raw[1];
            m_o3 = m_raw[2];
            en_v[0] = p1_en; en_v[1] = p2_en && !sync_en; en_v[2] = rec_en;
            want[0] = 256 >> p1_rate_sel;
            want[1] = share_div + 2;
            want[2] = share_div + 2;
            for (int i = 0; i < 3; i++) begin
                m_raw[i] = 0;
                if (!en_v[i]) m_cnt[i] = 0;
                else if (ref_tick) begin
                    if (m_cnt[i] == 0) m_per[i] = want[i];
                    if (m_cnt[i] + 1 == m_per[i]) begin
                        m_cnt[i] = 0;
                        m_raw[i] = 1;
                    end else m_cnt[i]++;
                end
            end
        end
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(p1_tick == m_o1, "R2 p1 model", p1_tick, m_o1);
            check(p2_tick == m_o2, "R3 p2 model", p2_tick, m_o2);
            check(rec_tick == m_o3, "R4 rec model", rec_tick, m_o3);
        end
    end

    task automatic wait_tick(input int ch, output int snap);
        forever begin
            @(negedge clk);
            if ((ch == 0 && p1_tick) || (ch == 1 && p2_tick) || (ch == 2 && rec_tick)) break;
        end
        snap = ref_total;
    endtask

    task automatic measure(input int ch, output int per);
        int a, b;
        wait_tick(ch, a);
        wait_tick(ch, b);
        per = b - a;
    endtask

    task automatic count_ticks(input int cycles, output int n1, output int n2, output int n3, output int mism);
        n1 = 0; n2 = 0; n3 = 0; mism = 0;
        repeat (cycles) begin
            @(negedge clk);
            n1 += int'(p1_tick); n2 += int'(p2_tick); n3 += int'(rec_tick);
            if (p1_tick != p2_tick) mism++;
        end
    endtask

    initial begin
        int per, a, b, n1, n2, n3, mm;
        // R1: reset state
        repeat (4) @(negedge clk);
        check(!p1_tick && !p2_tick && !rec_tick, "R1 in reset", {p1_tick, p2_tick, rec_tick}, 0);
        rst_n = 1'b1;
        count_ticks(40, n1, n2, n3, mm);
        check(n1 + n2 + n3 == 0, "R1 idle after reset", n1 + n2 + n3, 0);

        // R2: fixed rates
        p1_en = 1'b1;
        for (int s = 3; s >= 0; s--) begin
            p1_rate_sel = 2'(s);
            wait_tick(0, a);
            measure(0, per);
            check(per == (256 >> s), "R2 fixed period", per, 256 >> s);
        end
        p1_en = 1'b0;

        // R3: divider field, small and large
        p2_en = 1'b1;
        share_div = 13'd5;
        wait_tick(1, a);
        measure(1, per);
        check(per == 7, "R3 field 5", per, 7);
        ref_gap = 1;
        share_div = 13'd0;
        wait_tick(1, a);
        measure(1, per);
        check(per == 2, "R3 field 0", per, 2);
        count_ticks(20, n1, n2, n3, mm);
        check(n2 == 10, "R6 field 0 strobe count", n2, 10);
        share_div = 13'd8191;
        wait_tick(1, a);
        measure(1, per);
        check(per == 8193, "R3 field max", per, 8193);
        ref_gap = 3;

        // R7: change mid-period keeps current period
        share_div = 13'd10;
        wait_tick(1, a);
        wait_tick(1, a);
        repeat (9) @(negedge clk);       // three reference ticks into the period
        share_div = 13'd20;
        wait_tick(1, b);
        check(b - a == 12, "R7 old period completes", b - a, 12);
        measure(1, per);
        check(per == 22, "R7 new period applies", per, 22);
        p2_en = 1'b0;

        // R4: record channel alone, p2 quiet
        rec_en = 1'b1;
        share_div = 13'd14;
        wait_tick(2, a);
        measure(2, per);
        check(per == 16, "R4 record period", per, 16);
        count_ticks(200, n1, n2, n3, mm);
        check(n2 == 0, "R8 p2 disabled quiet", n2, 0);
        rec_en = 1'b0;

        // R5: lock mode
        p1_en = 1'b1; p1_rate_sel = 2'd3;
        p2_en = 1'b1; sync_en = 1'b1; share_div = 13'd3;
        count_ticks(1000, n1, n2, n3, mm);
        check(mm == 0, "R5 p2 aligned to p1", mm, 0);
        check(n2 == n1 && n1 > 0, "R5 p2 count equals p1", n2, n1);
        sync_en = 1'b0;
        measure(1, per);
        check(per == 5, "R3 own divider after unlock", per, 5);
        p2_en = 1'b0;

        // R8: disable mid-period, then full period after enable
        wait_tick(0, a);
        repeat (30) @(negedge clk);
        p1_en = 1'b0;
        count_ticks(200, n1, n2, n3, mm);
        check(n1 == 0, "R8 p1 disabled quiet", n1, 0);
        p1_en = 1'b1;
        a = ref_total;
        wait_tick(0, b);
        check(b - a == 32, "R8 full period after enable", b - a, 32);

        // R9: no reference ticks, no strobes
        rec_en = 1'b1; p2_en = 1'b1;
        ref_gap = 0;
        repeat (3) @(negedge clk);
        count_ticks(600, n1, n2, n3, mm);
        check(n1 + n2 + n3 == 0, "R9 no reference no strobe", n1 + n2 + n3, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        done = 1;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule